// File: doc/BRIEF.md
# Decrement-and-Branch Instruction Sequencer

This block is a multicycle control unit with its own small datapath. It carries out one instruction, "decrement a data byte and branch if the result is not zero", over and over. It drives two separate memory ports, one for program bytes and one for data bytes. It fetches a three-byte instruction from program memory: an opcode byte, then a data address byte, then a signed branch offset byte. It then reads the addressed data byte, decrements it, writes it back to the same location, and finally adjusts a 16-bit program counter by the offset if the new value is not zero.

Both memories are synchronous with one cycle of read latency. For every read the sequencer spends one state issuing the request and one state taking in the returned byte. A completed instruction is marked by a one-cycle completion pulse. An opcode that is not the decrement-and-branch code raises a sticky fault flag and freezes the sequencer until reset. On reset the program counter is loaded from a start-address input, and fetching begins there.

Top module: `dbr_sequencer`

## Requirements
- R1: During reset and in the first cycle after it, `pm_addr` equals `boot_pc`, `pm_rd` is 1, and `dm_rd`, `dm_wr`, `done` and `fault` are 0.
- R2: Program bytes are requested at three consecutive addresses: the instruction start, start+1 and start+2. Each request lasts one cycle. The first byte must be the opcode 0xD5, the second is the data address and the third is the branch offset.
- R3: After the fetch, exactly one data read is issued at the address taken from the second instruction byte.
- R4: Exactly one data write follows. It goes to the same address and writes the value read minus one, modulo 256, so 0x00 becomes 0xFF.
- R5: If the written value is nonzero, the next instruction address is start+3 plus the offset byte, read as signed two's complement and sign-extended to 16 bits. Offsets 0x80 to 0xFF therefore branch backwards.
- R6: If the written value is zero, the next instruction address is start+3.
- R7: `done` is a one-cycle pulse in the cycle where `pm_addr` first shows the next instruction address. An instruction takes 11 cycles from its opcode request to the next opcode request.
- R8: If the first byte is not 0xD5, `fault` rises and stays high. After that, `pm_rd`, `dm_rd`, `dm_wr` and `done` stay 0 until reset.
- R9: In any one cycle, at most one of `pm_rd`, `dm_rd` and `dm_wr` is high.
- R10: Reset clears `fault` and restarts fetching at the current `boot_pc`, including after a fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_pc | input | 16 | Program counter value loaded by reset |
| pm_addr | output | 16 | Program memory read address (the program counter) |
| pm_rd | output | 1 | Program memory read request |
| pm_rdata | input | 8 | Program memory byte, valid the cycle after a request |
| dm_addr | output | 8 | Data memory address |
| dm_rd | output | 1 | Data memory read request |
| dm_wr | output | 1 | Data memory write request |
| dm_wdata | output | 8 | Data memory write byte |
| dm_rdata | input | 8 | Data memory byte, valid the cycle after a read request |
| done | output | 1 | One-cycle pulse per completed instruction |
| fault | output | 1 | Sticky unknown-opcode flag |

## Verification
The bench builds the block with its default parameters: a 16-bit counter, 8-bit bytes and opcode 0xD5. With these values the offset must be sign-extended across eight upper bits. The extreme offsets 0x7F and 0x80 then give the largest forward and backward jumps, and an offset of 0xFD branches back to the instruction itself. The 8-bit data address lets the bench use both the lowest and the highest data locations. A data value of 0x00 covers the wrap to 0xFF, and a value of 0x01 covers the fall-through case.

// File: rtl/dbr_pkg.sv
package dbr_pkg;

  typedef enum logic [3:0] {
    S_OP_REQ,
    S_OP_LAT,
    S_AD_REQ,
    S_AD_LAT,
    S_OF_REQ,
    S_OF_LAT,
    S_RD_REQ,
    S_RD_LAT,
    S_DEC,
    S_WR,
    S_BR,
    S_HALT
  } seq_state_e;

endpackage

// File: rtl/dbr_ctrl.sv
module dbr_ctrl
  import dbr_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic op_ok,
  input  logic res_nz,
  output logic pm_rd,
  output logic dm_rd,
  output logic dm_wr,
  output logic done,
  output logic fault,
  output logic ld_ad,
  output logic ld_of,
  output logic ld_mdr,
  output logic dec_mdr,
  output logic pc_inc,
  output logic take_br,
  output logic br_state
);

  seq_state_e state, nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      S_OP_REQ: nxt = S_OP_LAT;
      S_OP_LAT: nxt = op_ok ? S_AD_REQ : S_HALT;
      S_AD_REQ: nxt = S_AD_LAT;
      S_AD_LAT: nxt = S_OF_REQ;
      S_OF_REQ: nxt = S_OF_LAT;
      S_OF_LAT: nxt = S_RD_REQ;
      S_RD_REQ: nxt = S_RD_LAT;
      S_RD_LAT: nxt = S_DEC;
      S_DEC:    nxt = S_WR;
      S_WR:     nxt = S_BR;
      S_BR:     nxt = S_OP_REQ;
      S_HALT:   nxt = S_HALT;
      default:  nxt = S_HALT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_OP_REQ;
      pm_rd <= 1'b1;
      dm_rd <= 1'b0;
      dm_wr <= 1'b0;
      done  <= 1'b0;
      fault <= 1'b0;
    end else begin
      state <= nxt;
      pm_rd <= (nxt == S_OP_REQ) || (nxt == S_AD_REQ) || (nxt == S_OF_REQ);
      dm_rd <= (nxt == S_RD_REQ);
      dm_wr <= (nxt == S_WR);
      done  <= (state == S_BR);
      fault <= fault || ((state == S_OP_LAT) && !op_ok);
    end
  end

  assign pc_inc   = (state == S_OP_LAT) || (state == S_AD_LAT) || (state == S_OF_LAT);
  assign ld_ad    = (state == S_AD_LAT);
  assign ld_of    = (state == S_OF_LAT);
  assign ld_mdr   = (state == S_RD_LAT);
  assign dec_mdr  = (state == S_DEC);
  assign br_state = (state == S_BR);
  assign take_br  = br_state && res_nz;

  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pm_rd, dm_rd, dm_wr}));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8
  fault_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    fault |=> fault);

  // R8
  halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    fault |-> !pm_rd && !dm_rd && !dm_wr && !done);

endmodule

// File: rtl/dbr_operands.sv
module dbr_operands #(
  parameter int              DW     = 8,
  parameter logic [DW-1:0]   OPCODE = 8'hD5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] pm_rdata,
  input  logic [DW-1:0] dm_rdata,
  input  logic          ld_ad,
  input  logic          ld_of,
  input  logic          ld_mdr,
  input  logic          dec_mdr,
  output logic          op_ok,
  output logic [DW-1:0] ad_q,
  output logic [DW-1:0] of_q,
  output logic [DW-1:0] mdr_q,
  output logic          res_nz
);

  localparam logic [DW-1:0] ONE = DW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      ad_q  <= '0;
      of_q  <= '0;
      mdr_q <= '0;
    end else begin
      if (ld_ad)   ad_q  <= pm_rdata;
      if (ld_of)   of_q  <= pm_rdata;
      if (ld_mdr)  mdr_q <= dm_rdata;
      else if (dec_mdr) mdr_q <= mdr_q - ONE;
    end
  end

  assign op_ok  = (pm_rdata == OPCODE);
  assign res_nz = |mdr_q;

  // R4
  mdr_dec_chk: assert property (@(posedge clk) disable iff (rst)
    dec_mdr |=> (mdr_q == DW'($past(mdr_q) - ONE)));

endmodule

// File: rtl/dbr_pc.sv
module dbr_pc #(
  parameter int PC_W = 16,
  parameter int OFS_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PC_W-1:0]  boot_pc,
  input  logic             inc,
  input  logic             take,
  input  logic [OFS_W-1:0] ofs,
  output logic [PC_W-1:0]  pc_q
);

  localparam int EXT_W = PC_W - OFS_W;
  localparam logic [PC_W-1:0] STEP = PC_W'(1);

  logic [PC_W-1:0] ofs_ext;

  generate
    if (EXT_W > 0) begin : g_ext
      assign ofs_ext = {{EXT_W{ofs[OFS_W-1]}}, ofs};
    end else begin : g_noext
      assign ofs_ext = ofs[PC_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)       pc_q <= boot_pc;
    else if (inc)  pc_q <= pc_q + STEP;
    else if (take) pc_q <= pc_q + ofs_ext;
  end

  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    inc |=> (pc_q == PC_W'($past(pc_q) + STEP)));

endmodule

// File: rtl/dbr_sequencer.sv
module dbr_sequencer #(
  parameter int            PC_W   = 16,
  parameter int            DW     = 8,
  parameter logic [DW-1:0] OPCODE = 8'hD5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] boot_pc,
  output logic [PC_W-1:0] pm_addr,
  output logic            pm_rd,
  input  logic [DW-1:0]   pm_rdata,
  output logic [DW-1:0]   dm_addr,
  output logic            dm_rd,
  output logic            dm_wr,
  output logic [DW-1:0]   dm_wdata,
  input  logic [DW-1:0]   dm_rdata,
  output logic            done,
  output logic            fault
);

  logic op_ok, res_nz;
  logic ld_ad, ld_of, ld_mdr, dec_mdr, pc_inc, take_br, br_state;
  logic [DW-1:0] of_q;

  dbr_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .op_ok    (op_ok),
    .res_nz   (res_nz),
    .pm_rd    (pm_rd),
    .dm_rd    (dm_rd),
    .dm_wr    (dm_wr),
    .done     (done),
    .fault    (fault),
    .ld_ad    (ld_ad),
    .ld_of    (ld_of),
    .ld_mdr   (ld_mdr),
    .dec_mdr  (dec_mdr),
    .pc_inc   (pc_inc),
    .take_br  (take_br),
    .br_state (br_state)
  );

  dbr_operands #(.DW(DW), .OPCODE(OPCODE)) u_opnd (
    .clk      (clk),
    .rst      (rst),
    .pm_rdata (pm_rdata),
    .dm_rdata (dm_rdata),
    .ld_ad    (ld_ad),
    .ld_of    (ld_of),
    .ld_mdr   (ld_mdr),
    .dec_mdr  (dec_mdr),
    .op_ok    (op_ok),
    .ad_q     (dm_addr),
    .of_q     (of_q),
    .mdr_q    (dm_wdata),
    .res_nz   (res_nz)
  );

  dbr_pc #(.PC_W(PC_W), .OFS_W(DW)) u_pc (
    .clk     (clk),
    .rst     (rst),
    .boot_pc (boot_pc),
    .inc     (pc_inc),
    .take    (take_br),
    .ofs     (of_q),
    .pc_q    (pm_addr)
  );

  // R6
  fall_through_chk: assert property (@(posedge clk) disable iff (rst)
    (br_state && !res_nz) |=> $stable(pm_addr));

  // R4
  wr_same_addr_chk: assert property (@(posedge clk) disable iff (rst)
    dm_wr |-> ($past(dm_rd, 3) && (dm_addr == $past(dm_addr, 3))));

  // R1
  boot_load_chk: assert property (@(posedge clk)
    rst |=> (pm_addr == $past(boot_pc)) && !fault && !done);

endmodule

// File: tb/test_dbr_sequencer.sv
module test_dbr_sequencer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] boot_pc = 16'h0000;
  logic [15:0] pm_addr;
  logic        pm_rd;
  logic [7:0]  pm_rdata = 8'h00;
  logic [7:0]  dm_addr;
  logic        dm_rd, dm_wr;
  logic [7:0]  dm_wdata;
  logic [7:0]  dm_rdata = 8'h00;
  logic        done, fault;

  logic [7:0] pmem [1024];
  logic [7:0] dmem [256];

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  dbr_sequencer i_dbr_sequencer (
    .clk(clk), .rst(rst), .boot_pc(boot_pc),
    .pm_addr(pm_addr), .pm_rd(pm_rd), .pm_rdata(pm_rdata),
    .dm_addr(dm_addr), .dm_rd(dm_rd), .dm_wr(dm_wr),
    .dm_wdata(dm_wdata), .dm_rdata(dm_rdata),
    .done(done), .fault(fault)
  );

  always @(posedge clk) begin
    if (pm_rd) pm_rdata <= pmem[pm_addr[9:0]];
    if (dm_wr) dmem[dm_addr] <= dm_wdata;
    if (dm_rd) dm_rdata <= dmem[dm_addr];
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  logic [15:0] pm_seen [4];
  int          n_pm, n_drd, n_dwr, n_cyc;
  logic [7:0]  drd_addr, dwr_addr, dwr_data;

  task automatic run_instr();
    n_pm = 0; n_drd = 0; n_dwr = 0; n_cyc = 0;
    do begin
      if (pm_rd) begin
        if (n_pm < 4) pm_seen[n_pm] = pm_addr;
        n_pm++;
      end
      if (dm_rd) begin n_drd++; drd_addr = dm_addr; end
      if (dm_wr) begin n_dwr++; dwr_addr = dm_addr; dwr_data = dm_wdata; end
      @(negedge clk);
      n_cyc++;
    end while (!done && n_cyc < 40);
  endtask

  task automatic do_reset(input logic [15:0] vec);
    @(negedge clk);
    rst = 1'b1;
    boot_pc = vec;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // {start pc, data address, offset, initial data}
  localparam logic [39:0] VEC [7] = '{
    40'h0010_21_0A_05,
    40'h0010_21_0A_01,
    40'h0100_7F_F0_03,
    40'h0200_00_80_00,
    40'h0300_FF_7F_80,
    40'h03F0_44_05_01,
    40'h0020_55_FD_02
  };

  initial begin : watchdog
    #2000000;
    n_bad++;
    $display("FAIL watchdog: got %h expected %h", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < 1024; i++) pmem[i] = 8'h00;
    for (int i = 0; i < 256; i++) dmem[i] = 8'h00;

    // R1: reset state
    do_reset(16'h0123);
    chk("R1", "pm_addr after reset", 32'(pm_addr), 32'h0123);
    chk("R1", "pm_rd after reset", 32'(pm_rd), 32'h1);
    chk("R1", "data strobes after reset", 32'({dm_rd, dm_wr}), 32'h0);
    chk("R1", "done/fault after reset", 32'({done, fault}), 32'h0);

    for (int v = 0; v < 7; v++) begin
      logic [15:0] st;
      logic [7:0]  ad, of, d0, d1;
      logic [15:0] exp_pc;
      st = VEC[v][39:24]; ad = VEC[v][23:16];
      of = VEC[v][15:8];  d0 = VEC[v][7:0];
      d1 = d0 - 8'h01;
      exp_pc = st + 16'h0003 + ((d1 != 8'h00) ? {{8{of[7]}}, of} : 16'h0000);
      pmem[st[9:0]]        = 8'hD5;
      pmem[st[9:0] + 10'd1] = ad;
      pmem[st[9:0] + 10'd2] = of;
      dmem[ad] = d0;
      do_reset(st);
      run_instr();
      chk("R2", "program read count", 32'(n_pm), 32'd3);
      chk("R2", "opcode address", 32'(pm_seen[0]), 32'(st));
      chk("R2", "offset address", 32'(pm_seen[2]), 32'(st + 16'd2));
      chk("R3", "data read count", 32'(n_drd), 32'd1);
      chk("R3", "data read address", 32'(drd_addr), 32'(ad));
      chk("R4", "write count", 32'(n_dwr), 32'd1);
      chk("R4", "write address", 32'(dwr_addr), 32'(ad));
      chk("R4", "write value", 32'(dwr_data), 32'(d1));
      @(negedge clk);
      chk("R4", "stored byte", 32'(dmem[ad]), 32'(d1));
      chk("R7", "cycles per instruction", 32'(n_cyc), 32'd11);
      chk("R7", "done single cycle", 32'(done), 32'h0);
      if (d1 != 8'h00) chk("R5", "taken branch pc", 32'(pm_addr), 32'(exp_pc));
      else             chk("R6", "fall-through pc", 32'(pm_addr), 32'(exp_pc));
      pmem[st[9:0]] = 8'h00;
    end

    // R5/R6: chained loop that branches to itself until the counter reaches zero
    pmem[10'h040] = 8'hD5; pmem[10'h041] = 8'h30; pmem[10'h042] = 8'hFD;
    pmem[10'h043] = 8'h12;
    dmem[8'h30] = 8'h03;
    do_reset(16'h0040);
    run_instr();
    chk("R5", "loop pass 1 pc", 32'(pm_addr), 32'h0040);
    chk("R7", "loop pass 1 done", 32'(done), 32'h1);
    run_instr();
    chk("R5", "loop pass 2 pc", 32'(pm_addr), 32'h0040);
    run_instr();
    chk("R6", "loop exit pc", 32'(pm_addr), 32'h0043);
    chk("R4", "loop counter", 32'(dmem[8'h30]), 32'h00);

    // R8: the next opcode 0x12 is not valid
    repeat (2) @(negedge clk);
    chk("R8", "fault raised", 32'(fault), 32'h1);
    for (int c = 0; c < 20; c++) begin
      if ({pm_rd, dm_rd, dm_wr, done} != 4'b0000 || !fault)
        chk("R8", "quiet while halted", 32'({fault, pm_rd, dm_rd, dm_wr, done}), 32'h10);
      @(negedge clk);
    end
    chk("R8", "fault still high", 32'(fault), 32'h1);
    chk("R8", "data untouched in halt", 32'(dmem[8'h30]), 32'h00);

    // R10: reset recovers from the fault
    do_reset(16'h0010);
    chk("R10", "fault cleared", 32'(fault), 32'h0);
    chk("R10", "restart address", 32'(pm_addr), 32'h0010);

    // R9: strobes exclusive across one full instruction
    pmem[10'h010] = 8'hD5; pmem[10'h011] = 8'h21; pmem[10'h012] = 8'h0A;
    dmem[8'h21] = 8'h05;
    begin
      int overlap;
      overlap = 0;
      for (int c = 0; c < 12; c++) begin
        if (32'(pm_rd) + 32'(dm_rd) + 32'(dm_wr) > 1) overlap++;
        @(negedge clk);
      end
      chk("R9", "strobe overlap cycles", 32'(overlap), 32'd0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule